// File: doc/BRIEF.md
# Converter Start-up and Alignment Sequencer

This block sequences a sampling converter through start-up, multi-device alignment and wake-up from power-down. It captures three control pins on the master clock: the active-low reset, the alignment pulse and the active-low power-down. From those registered copies it decides which settling interval applies and counts it exactly. After the interval it issues a one-cycle word-ready strobe on a fixed 64-cycle grid to the serial transmitter.

Calibration and filter settling are not computed here. They appear only as their durations, given as parameters (defaults 988,205, 5,161 and 5,168 master clocks) so that a bench can shrink them. Releasing reset starts a calibration. An alignment pulse moves the output phase without calibrating. Releasing power-down resumes output on the phase that was already in force.

Top module: `sls_settle_seq`

In the requirements, "edge E" is the first rising master-clock edge at which a pin is sampled at its new level.

## Requirements
- R1: While the registered reset is low, word_rdy, calibrating and settled are all 0. The registered reset clears at once when rst_pin_n goes low and sets on the first rising edge that samples rst_pin_n high.
- R2: When reset is released with its first high sample at edge E, calibrating is 1 after edges E through E+CAL_CYCLES-1 and 0 after edge E+CAL_CYCLES, so it is high for exactly CAL_CYCLES cycles.
- R3: After a reset release at edge E, the first word_rdy pulse and the rise of settled both follow edge E+CAL_CYCLES.
- R4: While settled stays 1, word_rdy is a single-cycle pulse repeated every WORD_PERIOD (64) cycles.
- R5: A rising edge of sync_pin, first sampled high at edge S, drops settled from the next edge and never raises calibrating. The next pulse follows edge S+SYNC_CYCLES, and later pulses keep 64-cycle spacing from it.
- R6: A sync rising edge that arrives while calibrating is 1 is ignored, so the first word still follows edge E+CAL_CYCLES.
- R7: A new sync rising edge during sync settling restarts the count, so the first word follows the second sync's edge plus SYNC_CYCLES.
- R8: When pwdn_pin_n is sampled low, word_rdy and settled are 0 from the next edge on. When it is sampled high again at edge P, settled rises after edge P+WAKE_CYCLES. Pulses then resume on the grid of the last reset or sync word, a whole number of 64-cycle periods after the last pulse before power-down.
- R9: While reset is active, sync and power-down have no effect. A reset released after they return to idle gives a normal calibration of CAL_CYCLES.
- R10: A reset low for a single master clock cycle restarts a full calibration. A sync high for a single cycle is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, rising edge active |
| rst_pin_n | input | 1 | Active-low reset request; release starts calibration |
| sync_pin | input | 1 | Alignment request; its rising edge re-phases the output grid |
| pwdn_pin_n | input | 1 | Active-low power-down request |
| word_rdy | output | 1 | One-cycle strobe marking a settled output word |
| calibrating | output | 1 | High while a calibration runs |
| settled | output | 1 | High while settled words are being produced |

## Verification
The properties assume that rst_pin_n is held low over at least one rising edge before anything else is looked at. They also assume WORD_PERIOD is at least 2 and that every settling count is at least 3. The bench meets this by starting in reset for several cycles and using counts of 300, 150 and 170. All pins are driven on the falling edge, so each pin is sampled at a single known rising edge. Every sync pulse is placed just after a word pulse, so the start of a measurement never falls on a grid slot.

// File: rtl/sls_pkg.sv
package sls_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_CAL   = 3'd1,
    ST_SYNC  = 3'd2,
    ST_PDOWN = 3'd3,
    ST_WAKE  = 3'd4,
    ST_RUN   = 3'd5
  } sls_state_e;

  // Value loaded into the down-counter so that the strobe follows edge
  // (event edge + cycles): one edge is spent recognising the event and one
  // in the final zero test.
  function automatic int unsigned settle_load(input int unsigned cycles);
    return (cycles >= 2) ? cycles - 2 : 0;
  endfunction

  // Width that holds the largest load value of the three intervals.
  function automatic int unsigned count_bits(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // True on the last phase step of an output period.
  function automatic logic phase_wraps(input int unsigned ph,
                                       input int unsigned period);
    return ph == period - 1;
  endfunction

endpackage

// File: rtl/sls_in_capture.sv
module sls_in_capture (
  input  logic mclk,
  input  logic rst_pin_n,
  input  logic sync_pin,
  input  logic pwdn_pin_n,
  output logic q_rst_n,
  output logic q_pwdn_n,
  output logic sync_rise
);

  logic q_sync;
  logic q_sync_d;

  // Reset capture: cleared at once by the pin, set on the clock.
  always_ff @(posedge mclk or negedge rst_pin_n) begin
    if (!rst_pin_n) q_rst_n <= 1'b0;
    else            q_rst_n <= 1'b1;
  end

  always_ff @(posedge mclk) begin
    q_sync   <= sync_pin;
    q_sync_d <= q_sync;
    q_pwdn_n <= pwdn_pin_n;
  end

  assign sync_rise = q_sync & ~q_sync_d;

endmodule

// File: rtl/sls_word_phase.sv
module sls_word_phase
  import sls_pkg::*;
#(
  parameter int unsigned PERIOD = 64
) (
  input  logic mclk,
  input  logic clear,
  input  logic realign,
  output logic slot
);

  localparam int unsigned PW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

  logic [PW-1:0] ph;

  assign slot = phase_wraps(32'(ph), PERIOD);

  always_ff @(posedge mclk) begin
    if (clear || realign) ph <= '0;
    else if (slot)        ph <= '0;
    else                  ph <= ph + PW'(1);
  end

endmodule

// File: rtl/sls_settle_ctrl.sv
module sls_settle_ctrl
  import sls_pkg::*;
#(
  parameter int unsigned CAL_CYCLES  = 988205,
  parameter int unsigned SYNC_CYCLES = 5161,
  parameter int unsigned WAKE_CYCLES = 5168,
  parameter int unsigned CW          = 20
) (
  input  logic       mclk,
  input  logic       q_rst_n,
  input  logic       q_pwdn_n,
  input  logic       sync_rise,
  input  logic       slot,
  output sls_state_e state,
  output logic       word_q,
  output logic       realign,
  output logic       clear_phase
);

  localparam logic [CW-1:0] CAL_LOAD  = CW'(settle_load(CAL_CYCLES));
  localparam logic [CW-1:0] SYNC_LOAD = CW'(settle_load(SYNC_CYCLES));
  localparam logic [CW-1:0] WAKE_LOAD = CW'(settle_load(WAKE_CYCLES));

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  sls_state_e    state_nxt;
  logic          word_nxt;
  logic          cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign clear_phase = (state == ST_RESET);

  // Priority: reset, then power-down, then sync, then the running count.
  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    word_nxt  = 1'b0;
    realign   = 1'b0;
    if (!q_rst_n) begin
      state_nxt = ST_RESET;
      cnt_nxt   = '0;
    end else if (state == ST_RESET) begin
      state_nxt = ST_CAL;
      cnt_nxt   = CAL_LOAD;
    end else if (!q_pwdn_n) begin
      state_nxt = ST_PDOWN;
    end else if (state == ST_PDOWN) begin
      state_nxt = ST_WAKE;
      cnt_nxt   = WAKE_LOAD;
    end else if (sync_rise && state != ST_CAL) begin
      state_nxt = ST_SYNC;
      cnt_nxt   = SYNC_LOAD;
    end else begin
      case (state)
        ST_CAL, ST_SYNC: begin
          if (cnt_zero) begin
            state_nxt = ST_RUN;
            word_nxt  = 1'b1;
            realign   = 1'b1;
          end else begin
            cnt_nxt = cnt - CW'(1);
          end
        end
        ST_WAKE: begin
          if (cnt_zero) begin
            state_nxt = ST_RUN;
            word_nxt  = slot;
          end else begin
            cnt_nxt = cnt - CW'(1);
          end
        end
        ST_RUN:  word_nxt  = slot;
        default: state_nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge mclk) begin
    state  <= state_nxt;
    cnt    <= cnt_nxt;
    word_q <= word_nxt;
  end

endmodule

// File: rtl/sls_settle_seq.sv
module sls_settle_seq
  import sls_pkg::*;
#(
  parameter int unsigned CAL_CYCLES  = 988205,
  parameter int unsigned SYNC_CYCLES = 5161,
  parameter int unsigned WAKE_CYCLES = 5168,
  parameter int unsigned WORD_PERIOD = 64
) (
  input  logic mclk,
  input  logic rst_pin_n,
  input  logic sync_pin,
  input  logic pwdn_pin_n,
  output logic word_rdy,
  output logic calibrating,
  output logic settled
);

  localparam int unsigned CW = count_bits(CAL_CYCLES, SYNC_CYCLES, WAKE_CYCLES);

  logic       q_rst_n;
  logic       q_pwdn_n;
  logic       sync_rise;
  logic       slot;
  logic       realign;
  logic       clear_phase;
  logic       word_q;
  sls_state_e state;

  sls_in_capture u_cap (
    .mclk       (mclk),
    .rst_pin_n  (rst_pin_n),
    .sync_pin   (sync_pin),
    .pwdn_pin_n (pwdn_pin_n),
    .q_rst_n    (q_rst_n),
    .q_pwdn_n   (q_pwdn_n),
    .sync_rise  (sync_rise)
  );

  sls_settle_ctrl #(
    .CAL_CYCLES  (CAL_CYCLES),
    .SYNC_CYCLES (SYNC_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES),
    .CW          (CW)
  ) u_ctrl (
    .mclk        (mclk),
    .q_rst_n     (q_rst_n),
    .q_pwdn_n    (q_pwdn_n),
    .sync_rise   (sync_rise),
    .slot        (slot),
    .state       (state),
    .word_q      (word_q),
    .realign     (realign),
    .clear_phase (clear_phase)
  );

  sls_word_phase #(
    .PERIOD (WORD_PERIOD)
  ) u_phase (
    .mclk    (mclk),
    .clear   (clear_phase),
    .realign (realign),
    .slot    (slot)
  );

  assign word_rdy    = q_rst_n & word_q;
  assign calibrating = q_rst_n & ((state == ST_RESET) || (state == ST_CAL));
  assign settled     = q_rst_n & (state == ST_RUN);

endmodule

// File: rtl/sls_settle_chk.sv
module sls_settle_chk #(
  parameter int unsigned CAL_CYCLES  = 988205,
  parameter int unsigned WORD_PERIOD = 64
) (
  input logic mclk,
  input logic q_rst_n,
  input logic word_rdy,
  input logic calibrating,
  input logic settled
);

  localparam int unsigned LW = $clog2(CAL_CYCLES + 2);
  localparam int unsigned GW = (WORD_PERIOD < 2) ? 1 : $clog2(WORD_PERIOD);

  logic [LW-1:0] cal_len;
  logic [GW-1:0] gap;

  always_ff @(posedge mclk) begin
    if (!q_rst_n)         cal_len <= '0;
    else if (calibrating) cal_len <= cal_len + LW'(1);
    else                  cal_len <= '0;
  end

  always_ff @(posedge mclk) begin
    if (!q_rst_n || word_rdy)       gap <= '0;
    else if (gap == GW'(WORD_PERIOD - 1)) gap <= '0;
    else                            gap <= gap + GW'(1);
  end

  AST_RESET_SILENT: assert property (@(posedge mclk) !q_rst_n |-> (!word_rdy && !calibrating && !settled)); // R1
  AST_CAL_QUIET: assert property (@(posedge mclk) disable iff (!q_rst_n) calibrating |-> (!word_rdy && !settled)); // R2
  AST_CAL_LENGTH: assert property (@(posedge mclk) disable iff (!q_rst_n) ($fell(calibrating) && settled) |-> cal_len == LW'(CAL_CYCLES)); // R2
  AST_FIRST_WORD: assert property (@(posedge mclk) disable iff (!q_rst_n) ($rose(settled) && $past(calibrating)) |-> word_rdy); // R3
  AST_PULSE_SINGLE: assert property (@(posedge mclk) disable iff (!q_rst_n) word_rdy |=> !word_rdy); // R4
  AST_WORD_SPACING: assert property (@(posedge mclk) disable iff (!q_rst_n) (word_rdy && $past(settled)) |-> gap == GW'(WORD_PERIOD - 1)); // R4

endmodule

bind sls_settle_seq sls_settle_chk #(
  .CAL_CYCLES  (CAL_CYCLES),
  .WORD_PERIOD (WORD_PERIOD)
) u_chk (
  .mclk        (mclk),
  .q_rst_n     (q_rst_n),
  .word_rdy    (word_rdy),
  .calibrating (calibrating),
  .settled     (settled)
);

// File: tb/tb_sls_settle_seq.sv
module tb_sls_settle_seq;

  localparam int CAL  = 300;
  localparam int SYN  = 150;
  localparam int WAKE = 170;
  localparam int PER  = 64;

  localparam int M_RST  = 0;
  localparam int M_CAL  = 1;
  localparam int M_SYN  = 2;
  localparam int M_PDN  = 3;
  localparam int M_WAKE = 4;
  localparam int M_RUN  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic pwdn_n = 1'b1;
  logic word_rdy, calibrating, settled;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  sls_settle_seq #(
    .CAL_CYCLES  (CAL),
    .SYNC_CYCLES (SYN),
    .WAKE_CYCLES (WAKE),
    .WORD_PERIOD (PER)
  ) dut (
    .mclk        (clk),
    .rst_pin_n   (rst_n),
    .sync_pin    (sync),
    .pwdn_pin_n  (pwdn_n),
    .word_rdy    (word_rdy),
    .calibrating (calibrating),
    .settled     (settled)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Behavioural reference: event edges and target edge numbers.
  int t = 0;
  int mode = M_RST;
  int target = 0;
  int anchor = 0;
  bit pr = 1'b0, ps = 1'b0, psd = 1'b0, pp = 1'b1;
  bit e_word = 1'b0, e_cal = 1'b0, e_set = 1'b0;

  always @(posedge clk) begin
    bit mw;
    bit on_grid;
    t++;
    mw = 1'b0;
    on_grid = (t > anchor) && (((t - anchor) % PER) == 0);
    if (!pr || !rst_n) begin
      mode = M_RST;
    end else if (mode == M_RST) begin
      mode = M_CAL; target = t - 1 + CAL; anchor = t;
    end else if (!pp) begin
      mode = M_PDN;
    end else if (mode == M_PDN) begin
      mode = M_WAKE; target = t - 1 + WAKE;
    end else if (ps && !psd && mode != M_CAL) begin
      mode = M_SYN; target = t - 1 + SYN;
    end else if ((mode == M_CAL || mode == M_SYN) && t == target) begin
      mode = M_RUN; mw = 1'b1; anchor = t;
    end else if (mode == M_WAKE && t == target) begin
      mode = M_RUN; mw = on_grid;
    end else if (mode == M_RUN) begin
      mw = on_grid;
    end
    psd = ps;
    pr = rst_n;
    ps = sync;
    pp = pwdn_n;
    e_word = pr & mw;
    e_cal  = pr & (mode == M_RST || mode == M_CAL);
    e_set  = pr & (mode == M_RUN);
  end

  always begin
    @(posedge clk);
    #5;
    check(tag, "word_rdy vs model", int'(word_rdy), int'(e_word));
    check(tag, "calibrating vs model", int'(calibrating), int'(e_cal));
    check(tag, "settled vs model", int'(settled), int'(e_set));
  end

  task automatic wait_word(output int n, output int cal_hi);
    n = 0;
    cal_hi = 0;
    do begin
      @(posedge clk);
      #5;
      n++;
      if (calibrating) cal_hi++;
    end while (!word_rdy && n < 5000);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, c, wl, hits;

    // R1: reset state
    repeat (5) @(posedge clk);
    #5;
    check("R1", "word_rdy in reset", int'(word_rdy), 0);
    check("R1", "calibrating in reset", int'(calibrating), 0);
    check("R1", "settled in reset", int'(settled), 0);

    // R2, R3: calibration after release
    tag = "R3";
    @(negedge clk) rst_n = 1'b1;
    wait_word(n, c);
    check("R3", "edges to first word", n, CAL + 1);
    check("R2", "calibrating cycles", c, CAL);
    check("R3", "settled with first word", int'(settled), 1);

    // R4: period
    tag = "R4";
    wait_word(n, c);
    check("R4", "word spacing", n, PER);
    wait_word(n, c);
    check("R4", "word spacing again", n, PER);

    // R5: sync re-aligns without calibrating
    tag = "R5";
    @(negedge clk) sync = 1'b1;
    fork
      wait_word(n, c);
      begin @(negedge clk) sync = 1'b0; end
    join
    check("R5", "edges sync to word", n, SYN + 1);
    check("R5", "calibrating during sync", c, 0);
    wait_word(n, c);
    check("R5", "spacing after sync", n, PER);

    // R7: second sync restarts the count
    tag = "R7";
    @(negedge clk) sync = 1'b1;
    fork
      wait_word(n, c);
      begin
        @(negedge clk) sync = 1'b0;
        repeat (59) @(negedge clk);
        sync = 1'b1;
        @(negedge clk) sync = 1'b0;
      end
    join
    check("R7", "edges to word with restart", n, 60 + SYN + 1);

    // R8: power-down and wake
    tag = "R8";
    wait_word(n, c);
    check("R4", "spacing before power-down", n, PER);
    wl = t;
    @(negedge clk) pwdn_n = 1'b0;
    @(posedge clk);
    hits = 0;
    repeat (29) begin
      @(posedge clk);
      #5;
      if (word_rdy || settled) hits++;
    end
    check("R8", "activity while powered down", hits, 0);
    @(negedge clk) pwdn_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      #5;
      n++;
    end while (!settled && n < 5000);
    check("R8", "edges wake to settled", n, WAKE + 1);
    if (!word_rdy) wait_word(n, c);
    check("R8", "grid offset after wake", (t - wl) % PER, 0);

    // R6, R10: one-cycle reset, then sync during calibration
    tag = "R6";
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    fork
      wait_word(n, c);
      begin
        repeat (100) @(negedge clk);
        sync = 1'b1;
        @(negedge clk) sync = 1'b0;
      end
    join
    check("R6", "edges to word with sync in calibration", n, CAL + 1);
    check("R10", "calibration after one-cycle reset", c, CAL);

    // R9: reset dominates sync and power-down
    tag = "R9";
    @(negedge clk) begin rst_n = 1'b0; pwdn_n = 1'b0; sync = 1'b1; end
    hits = 0;
    repeat (3) begin
      @(posedge clk);
      #5;
      if (word_rdy || calibrating || settled) hits++;
    end
    check("R9", "outputs during reset with sync and power-down", hits, 0);
    @(negedge clk) begin sync = 1'b0; pwdn_n = 1'b1; end
    @(negedge clk) rst_n = 1'b1;
    wait_word(n, c);
    check("R9", "edges to word after reset", n, CAL + 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule